// File: doc/BRIEF.md
# Keyed Configuration Port with Banked Device Registers

This block gives a host a two-address configuration window on a byte-wide I/O bus. One address is an index port and the other is a data port. At first the window is locked. The host opens it by writing an entry key to the index port a set number of times in a row. Once open, the host writes a register index to the index port and then reads or writes the data port.

The global registers are:
- a device selector, which picks the bank that the per-device indexes reach;
- read-only chip and vendor identification words, each read as a high byte and a low byte;
- a writable port-select byte.

Each device bank holds four bytes: an enable byte, the high and low bytes of a 16-bit base address, and an interrupt-select byte. Each bank's enable bit and base address leave the block as outputs, so that address decoders elsewhere can use them. Writing an exit key to the index port closes the window.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is locked and every bank byte is 0x00, so `dev_enable` and `dev_base` are all zero. The selector is 0x00 and port-select holds PORT_SEL_RST.
- R2: The window opens only after KEY_COUNT consecutive index-port writes of KEY_ENTER (default 0x87, twice). Any other index-port write made while locked restarts the count. Data-port accesses do not affect the count.
- R3: While locked, reads of either port return 0xFF and data-port writes change no register.
- R4: While open, an index-port write of KEY_EXIT (default 0xAA) locks the window. The index latch reads 0x00 after the next unlock.
- R5: While open, any other index-port write sets the index latch. Reading the index port returns the latched index.
- R6: The selector at index 0x07 reads back exactly what was written. It chooses the bank that indexes 0x30, 0x60, 0x61 and 0x70 address.
- R7: In the selected bank, the enable byte (0x30), base high (0x60), base low (0x61) and interrupt select (0x70) read back all eight bits as written. Banks are independent of each other.
- R8: Index 0x20/0x21 reads CHIP_ID high/low and index 0x23/0x24 reads VENDOR_ID high/low. Writes to these indexes have no effect.
- R9: Port-select at index 0x27 is read/write and resets to PORT_SEL_RST.
- R10: `dev_enable[n]` is bit 0 of bank n's enable byte. `dev_base[16n+15:16n]` is {base high, base low}. Both follow a data write at the clock edge that takes the write.
- R11: Bank contents survive locking and unlocking.
- R12: When the selector is NUM_DEV or above, bank-index writes are ignored and bank-index reads return 0x00. Unmapped indexes read 0x00.
- R13: Read data appears on `bus_rdata` at the clock edge that samples `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| dev_enable | output | NUM_DEV | Enable bit of each bank |
| dev_base | output | 16*NUM_DEV | Base address of each bank, bank n in bits 16n+15:16n |

## Verification
The bench builds the block with NUM_DEV=3, so selector value 3 is the first value with no bank behind it. This lets random selector writes reach the out-of-range path of R12 as well as the three real banks. KEY_COUNT stays at 2 and the identification words are set to distinct bytes. With these values, a broken unlock count, a swapped identification byte or a bank that leaks into another bank shows up both in readback and on `dev_base`.

// File: rtl/sio_cfg_pkg.sv
// Shared indexes and field codes for the keyed configuration port.
// Assumes 8-bit register indexes. The index values are fixed by the host's software.
package sio_cfg_pkg;
    localparam logic [7:0] IDX_SEL     = 8'h07;
    localparam logic [7:0] IDX_CHIP_HI = 8'h20;
    localparam logic [7:0] IDX_CHIP_LO = 8'h21;
    localparam logic [7:0] IDX_VEND_HI = 8'h23;
    localparam logic [7:0] IDX_VEND_LO = 8'h24;
    localparam logic [7:0] IDX_PSEL    = 8'h27;
    localparam logic [7:0] IDX_EN      = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_IRQ     = 8'h70;

    typedef enum logic [1:0] {
        FLD_EN  = 2'd0,
        FLD_BHI = 2'd1,
        FLD_BLO = 2'd2,
        FLD_IRQ = 2'd3
    } fld_e;

    // Maps an index to a bank field. The result is valid only when is_bank_idx holds.
    function automatic fld_e fld_of(input logic [7:0] idx);
        case (idx)
            IDX_BASE_HI: fld_of = FLD_BHI;
            IDX_BASE_LO: fld_of = FLD_BLO;
            IDX_IRQ:     fld_of = FLD_IRQ;
            default:     fld_of = FLD_EN;
        endcase
    endfunction

    function automatic logic is_bank_idx(input logic [7:0] idx);
        is_bank_idx = (idx == IDX_EN) || (idx == IDX_BASE_HI) ||
                      (idx == IDX_BASE_LO) || (idx == IDX_IRQ);
    endfunction
endpackage

// File: rtl/sio_unlock_fsm.sv
// Lock/unlock control. Counts consecutive entry-key writes to the index port
// and opens after KEY_COUNT of them. The exit key closes the window again.
// Assumes idx_wr is a one-cycle strobe for each index-port write.
module sio_unlock_fsm #(
    parameter int         KEY_COUNT = 2,
    parameter logic [7:0] KEY_ENTER = 8'h87,
    parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    localparam int CW = $clog2(KEY_COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(KEY_COUNT - 1);

    logic [CW-1:0] cnt_q;

    // Advances the key count while locked and handles the exit key while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            unlocked <= 1'b0;
        end else if (unlocked) begin
            if (idx_wr && wdata == KEY_EXIT) unlocked <= 1'b0;
        end else if (idx_wr) begin
            if (wdata == KEY_ENTER) begin
                if (cnt_q == LAST) begin
                    unlocked <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // R2: the window opens only on the final key of an unbroken run.
    assert_unlock_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_ENTER && cnt_q == LAST));

    // R4: the exit key locks the window on the next edge.
    assert_exit_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && idx_wr && wdata == KEY_EXIT) |=> !unlocked);
endmodule

// File: rtl/sio_dev_bank.sv
// One device register bank: enable, base high, base low and interrupt select.
// Drives the enable bit and the 16-bit base out for decoding.
// Assumes wr_en is qualified upstream (window open, this bank selected).
module sio_dev_bank
    import sio_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  fld_e        fld,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_data,
    output logic        enable_o,
    output logic [15:0] base_o
);
    logic [3:0][7:0] regs_q;

    // Stores one byte into the addressed field.
    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else if (wr_en) regs_q[fld] <= wdata;
    end

    // Selects the addressed field for readback.
    always_comb rd_data = regs_q[fld];

    assign enable_o = regs_q[FLD_EN][0];
    assign base_o   = {regs_q[FLD_BHI], regs_q[FLD_BLO]};

    // R11: the contents hold whenever no write reaches this bank.
    assert_bank_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    // R10: the base output follows a write of the low byte.
    assert_base_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld == FLD_BLO) |=> base_o[7:0] == $past(wdata));
endmodule

// File: rtl/sio_cfg_port.sv
// Keyed configuration port. Holds the index latch, the global registers, the
// banked device registers and the registered read path.
// Assumes single-cycle access strobes and at most one access per cycle.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          NUM_DEV      = 4,
    parameter int          KEY_COUNT    = 2,
    parameter logic [7:0]  KEY_ENTER    = 8'h87,
    parameter logic [7:0]  KEY_EXIT     = 8'hAA,
    parameter logic [15:0] CHIP_ID      = 16'h0A51,
    parameter logic [15:0] VENDOR_ID    = 16'h5CA3,
    parameter logic [7:0]  PORT_SEL_RST = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic                  bus_sel_data,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic [NUM_DEV-1:0]    dev_enable,
    output logic [16*NUM_DEV-1:0] dev_base
);
    logic         unlocked;
    logic [7:0]   idx_q;
    logic [7:0]   sel_q;
    logic [7:0]   psel_q;
    logic         idx_wr;
    logic         dat_wr;
    fld_e         fld;
    logic [NUM_DEV-1:0] bank_we;
    logic [7:0]   bank_rd [NUM_DEV];
    logic [7:0]   sel_bank_rd;
    logic         sel_valid;
    logic [7:0]   data_mux;

    assign idx_wr = bus_wr && !bus_sel_data;
    assign dat_wr = bus_wr && bus_sel_data && unlocked;
    assign fld    = fld_of(idx_q);

    sio_unlock_fsm #(
        .KEY_COUNT(KEY_COUNT),
        .KEY_ENTER(KEY_ENTER),
        .KEY_EXIT (KEY_EXIT)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .wdata   (bus_wdata),
        .unlocked(unlocked)
    );

    // Latches the index while open and clears it while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else if (!unlocked) idx_q <= '0;
        else if (idx_wr && bus_wdata != KEY_EXIT) idx_q <= bus_wdata;
    end

    // Holds the global device selector and the port-select byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            psel_q <= PORT_SEL_RST;
        end else if (dat_wr) begin
            if (idx_q == IDX_SEL)  sel_q  <= bus_wdata;
            if (idx_q == IDX_PSEL) psel_q <= bus_wdata;
        end
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
        assign bank_we[i] = dat_wr && is_bank_idx(idx_q) && (sel_q == 8'(i));
        sio_dev_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_we[i]),
            .fld     (fld),
            .wdata   (bus_wdata),
            .rd_data (bank_rd[i]),
            .enable_o(dev_enable[i]),
            .base_o  (dev_base[16*i +: 16])
        );
    end

    // Picks the selected bank's readback, or 0x00 when no bank matches.
    always_comb begin
        sel_bank_rd = '0;
        sel_valid   = 1'b0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (sel_q == 8'(i)) begin
                sel_bank_rd = bank_rd[i];
                sel_valid   = 1'b1;
            end
        end
    end

    // Data-port read multiplexer over the global and banked registers.
    always_comb begin
        case (idx_q)
            IDX_SEL:     data_mux = sel_q;
            IDX_CHIP_HI: data_mux = CHIP_ID[15:8];
            IDX_CHIP_LO: data_mux = CHIP_ID[7:0];
            IDX_VEND_HI: data_mux = VENDOR_ID[15:8];
            IDX_VEND_LO: data_mux = VENDOR_ID[7:0];
            IDX_PSEL:    data_mux = psel_q;
            default:     data_mux = (is_bank_idx(idx_q) && sel_valid) ? sel_bank_rd : 8'h00;
        endcase
    end

    // Registers read data on each read strobe and holds it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= 8'hFF;
        else if (bus_rd) begin
            if (!unlocked)         bus_rdata <= 8'hFF;
            else if (bus_sel_data) bus_rdata <= data_mux;
            else                   bus_rdata <= idx_q;
        end
    end

    // R3: a read made while locked returns 0xFF.
    assert_locked_read_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !unlocked) |=> bus_rdata == 8'hFF);

    // R3: no bank sees a write while the window is locked.
    assert_locked_no_bank_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> $countones(bank_we) == 0);

    // R13: read data holds when there is no read strobe.
    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R6: at most one bank is written per cycle.
    assert_one_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));
endmodule

// File: tb/sio_cfg_port_tb.sv
`timescale 1ns/1ps
module sio_cfg_port_tb;
    localparam int          N     = 3;
    localparam logic [7:0]  KEN   = 8'h87;
    localparam logic [7:0]  KEX   = 8'hAA;
    localparam logic [15:0] CID   = 16'h4C19;
    localparam logic [15:0] VID   = 16'hB2E6;
    localparam logic [7:0]  PSR   = 8'h4E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_data = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [N-1:0] dev_enable;
    logic [16*N-1:0] dev_base;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference state kept by the bench.
    bit         m_open;
    int         m_cnt;
    logic [7:0] m_idx, m_sel, m_psel;
    logic [7:0] m_bank [N][4];

    always #2 clk = ~clk;

    sio_cfg_port #(
        .NUM_DEV(N), .KEY_COUNT(2), .KEY_ENTER(KEN), .KEY_EXIT(KEX),
        .CHIP_ID(CID), .VENDOR_ID(VID), .PORT_SEL_RST(PSR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel_data(bus_sel_data), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_enable(dev_enable), .dev_base(dev_base)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int fld_num(input logic [7:0] idx);
        case (idx)
            8'h30: return 0;
            8'h60: return 1;
            8'h61: return 2;
            8'h70: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input bit sel);
        int f;
        if (!m_open) return 8'hFF;
        if (!sel) return m_idx;
        case (m_idx)
            8'h07: return m_sel;
            8'h20: return CID[15:8];
            8'h21: return CID[7:0];
            8'h23: return VID[15:8];
            8'h24: return VID[7:0];
            8'h27: return m_psel;
            default: begin
                f = fld_num(m_idx);
                if (f >= 0 && m_sel < N) return m_bank[m_sel][f];
                return 8'h00;
            end
        endcase
    endfunction

    task automatic model_reset();
        m_open = 0; m_cnt = 0; m_idx = 0; m_sel = 0; m_psel = PSR;
        for (int d = 0; d < N; d++) for (int f = 0; f < 4; f++) m_bank[d][f] = 0;
    endtask

    task automatic idx_write(input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1; bus_sel_data = 0; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
        if (!m_open) begin
            if (v == KEN) begin
                if (m_cnt == 1) begin m_open = 1; m_cnt = 0; m_idx = 0; end
                else m_cnt++;
            end else m_cnt = 0;
        end else if (v == KEX) begin
            m_open = 0; m_idx = 0;
        end else m_idx = v;
    endtask

    task automatic data_write(input logic [7:0] v);
        int f;
        @(negedge clk);
        bus_wr = 1; bus_sel_data = 1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
        if (m_open) begin
            if (m_idx == 8'h07) m_sel = v;
            if (m_idx == 8'h27) m_psel = v;
            f = fld_num(m_idx);
            if (f >= 0 && m_sel < N) m_bank[m_sel][f] = v;
        end
    endtask

    task automatic read_check(input bit sel, input string tag);
        logic [7:0] e;
        e = exp_read(sel);
        @(negedge clk);
        bus_rd = 1; bus_sel_data = sel;
        @(negedge clk);
        bus_rd = 0;
        check(bus_rdata == e, tag, bus_rdata, e);
    endtask

    task automatic outputs_check(input string tag);
        for (int d = 0; d < N; d++) begin
            check(dev_enable[d] == m_bank[d][0][0], tag, dev_enable[d], m_bank[d][0][0]);
            check(dev_base[16*d +: 16] == {m_bank[d][1], m_bank[d][2]}, tag,
                  dev_base[16*d +: 16], {m_bank[d][1], m_bank[d][2]});
        end
    endtask

    task automatic unlock();
        idx_write(KEN); idx_write(KEN);
    endtask

    function automatic logic [7:0] pick_idx(input int r);
        case (r % 12)
            0: return 8'h07;  1: return 8'h20;  2: return 8'h21;  3: return 8'h23;
            4: return 8'h24;  5: return 8'h27;  6: return 8'h30;  7: return 8'h60;
            8: return 8'h61;  9: return 8'h70;  10: return 8'h45; default: return 8'h31;
        endcase
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state at the outputs.
        @(negedge clk);
        check(dev_enable == 0, "R1", dev_enable, 0);
        check(dev_base == 0, "R1", 0, 0);
        read_check(1, "R3");
        read_check(0, "R3");

        // R2: a broken key run does not open the window.
        idx_write(KEN); idx_write(8'h55); idx_write(KEN);
        read_check(1, "R2");
        data_write(8'h12);     // data access does not affect the key count
        idx_write(KEN);
        read_check(0, "R2");

        // R9 and R6: reset values after unlock.
        idx_write(8'h27); read_check(1, "R9");
        data_write(8'h3C); read_check(1, "R9");
        idx_write(8'h07); read_check(1, "R6");

        // R8: identification bytes, and writes to them ignored.
        idx_write(8'h20); read_check(1, "R8");
        data_write(8'h00); read_check(1, "R8");
        idx_write(8'h21); read_check(1, "R8");
        idx_write(8'h23); read_check(1, "R8");
        idx_write(8'h24); data_write(8'hFF); read_check(1, "R8");

        // R7 and R10: fill bank 1, then read back and check the outputs.
        idx_write(8'h07); data_write(8'h01); read_check(1, "R6");
        idx_write(8'h30); data_write(8'hA5); read_check(1, "R7");
        idx_write(8'h60); data_write(8'hC3); read_check(1, "R7");
        idx_write(8'h61); data_write(8'h5A); read_check(1, "R7");
        idx_write(8'h70); data_write(8'h0B); read_check(1, "R7");
        outputs_check("R10");
        idx_write(8'h07); data_write(8'h00);
        idx_write(8'h61); read_check(1, "R7");

        // R5: the index latch reads back.
        idx_write(8'h61); read_check(0, "R5");

        // R12: an out-of-range selector and an unmapped index.
        idx_write(8'h07); data_write(8'h03);
        idx_write(8'h30); data_write(8'hFF); read_check(1, "R12");
        outputs_check("R12");
        idx_write(8'h45); read_check(1, "R12");

        // R4, R3 and R11: lock, try a write, then reopen and check retention.
        idx_write(KEX); read_check(1, "R4");
        data_write(8'h77); outputs_check("R3");
        unlock(); read_check(0, "R4");
        idx_write(8'h07); data_write(8'h01);
        idx_write(8'h60); read_check(1, "R11");
        outputs_check("R11");

        // R13: read data holds through later writes.
        idx_write(8'h70); read_check(1, "R13");
        hold = bus_rdata;
        data_write(8'h99); idx_write(8'h30);
        check(bus_rdata == hold, "R13", bus_rdata, hold);

        // Random mix of accesses against the bench's reference state.
        void'($urandom(32'd20240611));
        for (int it = 0; it < 1500; it++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: idx_write(KEN);
                1: idx_write(8'($urandom));
                2: if ($urandom_range(0, 3) == 0) idx_write(KEX);
                3, 4: begin idx_write(pick_idx($urandom)); data_write(8'($urandom)); end
                5, 6: begin idx_write(pick_idx($urandom)); read_check(1, "R7"); end
                7: read_check(0, "R5");
                8: begin idx_write(8'h07); data_write(8'($urandom_range(0, N))); end
                default: begin if (!m_open) unlock(); read_check(1, "R6"); end
            endcase
            outputs_check("R10");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule